// File: doc/BRIEF.md
# Transaction-Indexed Buffer Pointer

This block produces the byte address that a host uses to reach a channel's data buffer. The host does not deal in flat addresses. It names a transaction and a byte offset inside that transaction, and the block places the pointer there. The start address of a transaction is the sum of the lengths of every configured transaction below it. Those lengths come from a configuration table held outside the block. Slave addresses are kept elsewhere and take no room in the buffer. The buffer is a single-port RAM with one cycle of read latency, placed next to the block. The block drives the RAM's enable, write strobe, address and write data, and it receives the RAM's read data.

Host accesses arrive on a request stream: `acc_valid_i` qualified by `acc_ready_o`. Each accepted access that lands inside the configured region moves the pointer forward by one byte. The pointer runs off the end of one transaction straight into the next. A pointer-reset command sends the pointer back to the last chosen transaction and offset. Any access at or past the configured end, or past the physical depth, is a buffer error. On a buffer error the RAM is not touched, a read returns all ones, and the pointer stays where it is.

Back-pressure works only on the request side. `acc_ready_o` falls for exactly one cycle after any select write, offset write, pointer reset or table-change strobe, while the new position is loaded. It also stays low for one cycle after reset. A request presented while ready is low is not taken and has no effect. A command that arrives in the same cycle as an accepted access lets that access use the old pointer. Read responses cannot be stalled: `rd_valid_o` is asserted exactly one cycle after an accepted read.

Top module: `txn_buf_ptr`

## Requirements
- R1: After reset the home position is transaction 0, offset 0. `acc_ready_o` is high from the second falling clock edge after reset is released. While reset is held, `mem_en_o`, `err_o` and `rd_valid_o` are low.
- R2: The first access after a new home is loaded uses a buffer address equal to the home offset plus the sum of the lengths of the configured transactions whose index is below the selected one.
- R3: Only transactions with index below `txn_cnt_i` are configured. Length entries at or above that count add nothing to any base or to the end. Selecting such a transaction puts the pointer at or past the end, so the access is a buffer error.
- R4: Each accepted access that has no error moves the next address up by one. This crosses from the last byte of one transaction into the first byte of the next configured one, and zero-length transactions are skipped.
- R5: `ptr_rst_i` returns the pointer to the position given by the stored select and offset values, whatever accesses have happened since.
- R6: An accepted access at an address greater than or equal to min(configured total, DEPTH) keeps `mem_en_o` and `mem_we_o` low. It pulses `err_o` high in the following cycle and leaves the pointer unchanged.
- R7: An accepted read gives `rd_valid_o` one cycle later. `rd_data_o` carries the RAM data, or all ones if the read was a buffer error.
- R8: `acc_ready_o` is low in the cycle after a select write, offset write, pointer reset or table-change strobe. It is high again one cycle later if no new command arrives. A request made while ready is low reaches neither the RAM nor the pointer.
- R9: After `tbl_chg_i`, the home position is recomputed from the lengths currently on `len_tbl_i`.
- R10: `mem_we_o` is high only for accepted, error-free writes, and `mem_wdata_o` then equals `acc_wdata_i`. Data written this way is read back unchanged at the same transaction and offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_tbl_i | input | N_TXN*LEN_W | Length of each transaction; entry k is at bits k*LEN_W upward |
| txn_cnt_i | input | $clog2(N_TXN)+1 | Number of configured transactions |
| tbl_chg_i | input | 1 | Strobe: the length table or the count has changed |
| sel_we_i | input | 1 | Write strobe for the transaction select value |
| sel_i | input | $clog2(N_TXN) | Transaction select value |
| ofs_we_i | input | 1 | Write strobe for the byte offset value |
| ofs_i | input | LEN_W | Byte offset within the selected transaction |
| ptr_rst_i | input | 1 | Return the pointer to the stored select and offset |
| acc_valid_i | input | 1 | Host access request valid |
| acc_ready_o | output | 1 | Access request accepted when high together with valid |
| acc_we_i | input | 1 | Request is a write (1) or a read (0) |
| acc_wdata_i | input | DATA_W | Write data of the request |
| mem_en_o | output | 1 | RAM enable |
| mem_we_o | output | 1 | RAM write strobe |
| mem_addr_o | output | $clog2(DEPTH) | RAM byte address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after enable |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | DATA_W | Read response data |
| err_o | output | 1 | One-cycle buffer error pulse |

## Verification
The pointer and the error decision are internal, and both show up on the RAM address and on `mem_en_o` during the access itself. A wrong base, a missed increment or a stale end therefore appears as a wrong address or a missing enable on the very first access after the fault, with no delay. A wrong pointer-hold on error is seen on the next access, as is a corrupted read mask one cycle later on `rd_data_o`. The bench sweeps a small configuration over every select, offset, count and several length patterns. It does this so that each of these faults reaches the ports within a few accesses.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int unsigned DEF_N_TXN  = 64;
  localparam int unsigned DEF_LEN_W  = 8;
  localparam int unsigned DEF_DEPTH  = 4352;
  localparam int unsigned DEF_DATA_W = 8;

  // width needed to hold the sum of n lengths of lw bits each
  function automatic int unsigned sum_width(input int unsigned n, input int unsigned lw);
    int unsigned maxv;
    maxv = n * ((32'd1 << lw) - 1) + 1;
    return (maxv <= 2) ? 1 : $clog2(maxv);
  endfunction
endpackage

// File: rtl/tbp_prefix.sv
module tbp_prefix #(
  parameter int unsigned N_TXN = tbp_pkg::DEF_N_TXN,
  parameter int unsigned LEN_W = tbp_pkg::DEF_LEN_W,
  parameter int unsigned SEL_W = $clog2(N_TXN),
  parameter int unsigned SUM_W = tbp_pkg::sum_width(N_TXN, LEN_W)
) (
  input  logic [N_TXN*LEN_W-1:0] len_tbl_i,
  input  logic [SEL_W:0]         txn_cnt_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [SUM_W-1:0]       base_o,
  output logic [SUM_W-1:0]       total_o
);
  logic [SUM_W-1:0] run [N_TXN+1];

  assign run[0] = '0;

  for (genvar g = 0; g < N_TXN; g++) begin : g_chain
    logic [SUM_W-1:0] term;
    assign term = (32'(g) < 32'(txn_cnt_i)) ? SUM_W'(len_tbl_i[g*LEN_W +: LEN_W]) : '0;
    assign run[g+1] = run[g] + term;
  end

  assign base_o  = run[sel_i];
  assign total_o = run[N_TXN];
endmodule

// File: rtl/tbp_cursor.sv
module tbp_cursor #(
  parameter int unsigned LEN_W = tbp_pkg::DEF_LEN_W,
  parameter int unsigned SEL_W = 6,
  parameter int unsigned SUM_W = 14,
  parameter int unsigned PW    = SUM_W + 1,
  parameter int unsigned DEPTH = tbp_pkg::DEF_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ofs_we_i,
  input  logic [LEN_W-1:0] ofs_i,
  input  logic             reload_i,
  input  logic             step_i,
  input  logic [SUM_W-1:0] base_i,
  input  logic [SUM_W-1:0] total_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [PW-1:0]    ptr_o,
  output logic [PW-1:0]    end_o,
  output logic             load_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [SEL_W-1:0] sel_q;
  logic [LEN_W-1:0] ofs_q;
  logic [PW-1:0]    ptr_q, end_q, end_d, home_d;
  logic             load_q;

  always_comb begin
    end_d  = (PW'(total_i) > DEPTH_P) ? DEPTH_P : PW'(total_i);
    home_d = PW'(base_i) + PW'(ofs_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ofs_q  <= '0;
      ptr_q  <= '0;
      end_q  <= '0;
      load_q <= 1'b1;
    end else begin
      if (sel_we_i) sel_q <= sel_i;
      if (ofs_we_i) ofs_q <= ofs_i;
      end_q  <= end_d;
      load_q <= reload_i;
      if (load_q)      ptr_q <= home_d;
      else if (step_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign sel_o  = sel_q;
  assign ptr_o  = ptr_q;
  assign end_o  = end_q;
  assign load_o = load_q;
endmodule

// File: rtl/tbp_port.sv
module tbp_port #(
  parameter int unsigned PW     = 15,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = tbp_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     ptr_i,
  input  logic [PW-1:0]     end_i,
  input  logic              load_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic              acc_ready_o,
  output logic              step_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o
);
  logic fire, outside;
  logic rd_valid_q, rd_bad_q, err_q;

  assign acc_ready_o = !load_i;
  assign fire        = acc_valid_i && acc_ready_o;
  assign outside     = (ptr_i >= end_i);
  assign step_o      = fire && !outside;

  assign mem_en_o    = step_o;
  assign mem_we_o    = step_o && acc_we_i;
  assign mem_addr_o  = ptr_i[ADDR_W-1:0];
  assign mem_wdata_o = acc_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_bad_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= fire && !acc_we_i;
      rd_bad_q   <= fire && outside;
      err_q      <= fire && outside;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_bad_q ? {DATA_W{1'b1}} : mem_rdata_i;
  assign err_o      = err_q;
endmodule

// File: rtl/txn_buf_ptr.sv
module txn_buf_ptr #(
  parameter int unsigned N_TXN  = tbp_pkg::DEF_N_TXN,
  parameter int unsigned LEN_W  = tbp_pkg::DEF_LEN_W,
  parameter int unsigned DEPTH  = tbp_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W = tbp_pkg::DEF_DATA_W,
  localparam int unsigned SEL_W  = $clog2(N_TXN),
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_TXN*LEN_W-1:0] len_tbl_i,
  input  logic [SEL_W:0]         txn_cnt_i,
  input  logic                   tbl_chg_i,
  input  logic                   sel_we_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic                   ofs_we_i,
  input  logic [LEN_W-1:0]       ofs_i,
  input  logic                   ptr_rst_i,
  input  logic                   acc_valid_i,
  output logic                   acc_ready_o,
  input  logic                   acc_we_i,
  input  logic [DATA_W-1:0]      acc_wdata_i,
  output logic                   mem_en_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   rd_valid_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   err_o
);
  localparam int unsigned SUM_W = tbp_pkg::sum_width(N_TXN, LEN_W);
  localparam int unsigned PW    = ((SUM_W > ADDR_W) ? SUM_W : ADDR_W) + 1;

  logic [SEL_W-1:0] sel_q;
  logic [SUM_W-1:0] base, total;
  logic [PW-1:0]    ptr, end_pos;
  logic             load, step, reload;

  assign reload = sel_we_i || ofs_we_i || ptr_rst_i || tbl_chg_i;

  tbp_prefix #(
    .N_TXN(N_TXN), .LEN_W(LEN_W), .SEL_W(SEL_W), .SUM_W(SUM_W)
  ) u_prefix (
    .len_tbl_i(len_tbl_i), .txn_cnt_i(txn_cnt_i), .sel_i(sel_q),
    .base_o(base), .total_o(total)
  );

  tbp_cursor #(
    .LEN_W(LEN_W), .SEL_W(SEL_W), .SUM_W(SUM_W), .PW(PW), .DEPTH(DEPTH)
  ) u_cursor (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_we_i(sel_we_i), .sel_i(sel_i), .ofs_we_i(ofs_we_i), .ofs_i(ofs_i),
    .reload_i(reload), .step_i(step), .base_i(base), .total_i(total),
    .sel_o(sel_q), .ptr_o(ptr), .end_o(end_pos), .load_o(load)
  );

  tbp_port #(
    .PW(PW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ptr_i(ptr), .end_i(end_pos), .load_i(load),
    .acc_valid_i(acc_valid_i), .acc_we_i(acc_we_i), .acc_wdata_i(acc_wdata_i),
    .acc_ready_o(acc_ready_o), .step_o(step),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .err_o(err_o)
  );
endmodule

// File: rtl/txn_buf_ptr_chk.sv
module txn_buf_ptr_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tbl_chg_i,
  input logic              sel_we_i,
  input logic              ofs_we_i,
  input logic              ptr_rst_i,
  input logic              acc_valid_i,
  input logic              acc_ready_o,
  input logic              acc_we_i,
  input logic [DATA_W-1:0] acc_wdata_i,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              err_o
);
  logic cmd, fire;
  assign cmd  = tbl_chg_i || sel_we_i || ofs_we_i || ptr_rst_i;
  assign fire = acc_valid_i && acc_ready_o;

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd |=> !acc_ready_o); // R8
  AST_EN_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> fire); // R8
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !cmd) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R4
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mem_en_o) |=> err_o); // R6
  AST_ERR_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !err_o); // R6
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mem_en_o && !cmd) |=> $stable(mem_addr_o)); // R6
  AST_RD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !acc_we_i) |=> rd_valid_o); // R7
  AST_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && err_o) |-> (rd_data_o == {DATA_W{1'b1}})); // R7
  AST_WE_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_en_o && acc_we_i && mem_wdata_o == acc_wdata_i)); // R10
endmodule

bind txn_buf_ptr txn_buf_ptr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tbl_chg_i(tbl_chg_i), .sel_we_i(sel_we_i),
  .ofs_we_i(ofs_we_i), .ptr_rst_i(ptr_rst_i), .acc_valid_i(acc_valid_i),
  .acc_ready_o(acc_ready_o), .acc_we_i(acc_we_i), .acc_wdata_i(acc_wdata_i),
  .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .err_o(err_o)
);

// File: tb/sim_txn_buf_ptr.sv
`timescale 1ns/1ps
module sim_txn_buf_ptr;
  localparam int NT = 4;
  localparam int LW = 3;
  localparam int DP = 20;
  localparam int AW = $clog2(DP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT*LW-1:0] len_tbl = '0;
  logic [2:0] txn_cnt = '0;
  logic tbl_chg = 0, sel_we = 0, ofs_we = 0, ptr_rst = 0;
  logic [1:0] sel = '0;
  logic [LW-1:0] ofs = '0;
  logic acc_valid = 0, acc_we = 0;
  logic [7:0] acc_wdata = '0;
  logic acc_ready, mem_en, mem_we, rd_valid, err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, rd_data;
  logic [7:0] ram [DP];

  int vectors = 0;
  int fails = 0;
  int lens [NT];

  always #2 clk = ~clk;

  txn_buf_ptr #(.N_TXN(NT), .LEN_W(LW), .DEPTH(DP), .DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .len_tbl_i(len_tbl), .txn_cnt_i(txn_cnt),
    .tbl_chg_i(tbl_chg), .sel_we_i(sel_we), .sel_i(sel), .ofs_we_i(ofs_we),
    .ofs_i(ofs), .ptr_rst_i(ptr_rst), .acc_valid_i(acc_valid), .acc_ready_o(acc_ready),
    .acc_we_i(acc_we), .acc_wdata_i(acc_wdata), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_base(input int s, input int c);
    int b = 0;
    for (int k = 0; k < NT; k++) if (k < s && k < c) b += lens[k];
    return b;
  endfunction

  function automatic int exp_end(input int c);
    int e = exp_base(NT, c);
    return (e > DP) ? DP : e;
  endfunction

  task automatic load_table(input int l0, input int l1, input int l2, input int l3, input int c);
    lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
    @(negedge clk);
    len_tbl = {LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
    txn_cnt = 3'(c);
    tbl_chg = 1;
    @(negedge clk);
    tbl_chg = 0;
    @(negedge clk);
  endtask

  task automatic set_home(input int s, input int o);
    @(negedge clk);
    sel = 2'(s); ofs = LW'(o); sel_we = 1; ofs_we = 1;
    @(negedge clk);
    sel_we = 0; ofs_we = 0;
    #1 check("R8 ready low after command", int'(acc_ready), 0);
    @(negedge clk);
    #1 check("R8 ready back high", int'(acc_ready), 1);
  endtask

  task automatic do_acc(input bit we, input logic [7:0] wd, output int en, output int wen,
                        output int addr, output int e, output int rv, output int rd);
    @(negedge clk);
    acc_valid = 1; acc_we = we; acc_wdata = wd;
    #1 en = int'(mem_en); wen = int'(mem_we); addr = int'(mem_addr);
    @(negedge clk);
    acc_valid = 0; acc_we = 0;
    #1 e = int'(err); rv = int'(rd_valid); rd = int'(rd_data);
  endtask

  task automatic sweep_home(input int c);
    int en, wen, a, e, rv, rd, p, lim;
    lim = exp_end(c);
    for (int s = 0; s < NT; s++) begin
      for (int o = 0; o < (1 << LW); o++) begin
        set_home(s, o);
        p = exp_base(s, c) + o;
        for (int st = 0; st < 3; st++) begin
          do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
          if (p >= lim) begin
            check((s >= c) ? "R3 unconfigured select errors" : "R6 no RAM enable on error", en, 0);
            check("R6 error pulse", e, 1);
            check("R7 read masked to all ones", rd, 255);
          end else begin
            check((st == 0) ? "R2 first address" : "R4 advanced address", a, p);
            check("R6 no error inside region", e, 0);
            p++;
          end
          check("R7 read response valid", rv, 1);
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int en, wen, a, e, rv, rd;
    lens[0] = 1; lens[1] = 2; lens[2] = 3; lens[3] = 4;
    len_tbl = {3'(4), 3'(3), 3'(2), 3'(1)};
    txn_cnt = 3'd4;
    repeat (3) @(negedge clk);
    #1 check("R1 no enable in reset", int'(mem_en), 0);
    check("R1 no error in reset", int'(err), 0);
    check("R1 no response in reset", int'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    #1 check("R1 ready after reset", int'(acc_ready), 1);
    do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
    check("R1 home address zero", a, 0);
    check("R1 enable at home", en, 1);

    // R2 R3 R4 R6 R7: sweep over count, select, offset and length patterns
    for (int c = 0; c <= NT; c++) begin load_table(1, 2, 3, 4, c); sweep_home(c); end
    for (int c = 0; c <= NT; c++) begin load_table(7, 0, 5, 7, c); sweep_home(c); end
    for (int c = 0; c <= NT; c++) begin load_table(0, 3, 0, 6, c); sweep_home(c); end
    load_table(7, 7, 7, 7, 4); sweep_home(4);

    // R10: fill the clamped region, overrun once, rewind and read back
    load_table(7, 7, 7, 7, 4);
    set_home(0, 0);
    for (int i = 0; i < DP; i++) begin
      do_acc(1'b1, 8'(i * 3 + 1), en, wen, a, e, rv, rd);
      check("R10 write strobe", wen, 1);
      check("R10 write address", a, i);
    end
    do_acc(1'b1, 8'hAA, en, wen, a, e, rv, rd);
    check("R6 overrun write suppressed", wen, 0);
    check("R6 overrun error", e, 1);
    @(negedge clk); ptr_rst = 1; @(negedge clk); ptr_rst = 0;
    for (int i = 0; i < DP; i++) begin
      do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
      check("R10 read back data", rd, (i * 3 + 1) & 255);
    end

    // R5: rewind after partial progress, home txn 1 offset 2
    load_table(1, 2, 3, 4, 4);
    set_home(1, 2);
    do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
    do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
    check("R5 progressed before rewind", a, 4);
    @(negedge clk); ptr_rst = 1; @(negedge clk); ptr_rst = 0;
    // R8: request while ready is low has no effect
    acc_valid = 1;
    #1 check("R8 no enable while not ready", int'(mem_en), 0);
    @(negedge clk); acc_valid = 0;
    do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
    check("R5 rewound to home", a, 3);

    // R9: length change moves the home of txn 2
    set_home(2, 0);
    load_table(2, 2, 3, 4, 4);
    do_acc(1'b0, 8'h00, en, wen, a, e, rv, rd);
    check("R9 home follows new lengths", a, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule